// File: doc/BRIEF.md
# Core Memory Module Emulator

This block takes the place of one magnetic-core storage module in an older machine. Storage is a synchronous RAM array built into the block. The host machine still drives the same signals it would send to a core stack: an address bus, a module-select line, a read strobe, a write strobe and a restore/write data bus. A counter running on the system clock does the work that a tapped delay line once did.

The block behaves like a destructive-read core cycle. The rising edge of the read strobe captures the address. Some fifteen clock cycles later, a ten-cycle sense window opens. Inside that window, every bit of the stored word that holds a one produces a positive pulse on its sense line. A bit that holds a zero stays low for the whole cycle.

The host then raises the write strobe to restore or replace the word. The block stores the write data into the address captured at the start of the cycle, even if the address bus has changed since then. A write strobe that arrives without a read earlier in the same cycle is still carried out. In that case the write goes to the address on the bus, and a one-cycle error flag reports the broken protocol. The word is split across two storage banks: the low 8 bits are in one bank and the upper 4 bits are in the other.

Top module: `cmem_emu`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `sense_out` is all zeros and `proto_err` is low.
- R2: The rising edge of `rd_strobe` (with `sel` high) captures `addr`. The later write of the same cycle uses that captured address. A change on `addr` after the rising edge has no effect on which location is written.
- R3: Number the clock edge that first samples `rd_strobe` high as edge 0. After edges 16 to 25, `sense_out` equals the stored word, with bit i high exactly when stored bit i is one. A 26-cycle read strobe therefore gives exactly 10 pulse cycles on each one-bit.
- R4: Outside that window, and after any edge that samples `rd_strobe` low, `sense_out` is zero. A read strobe held high for 20 cycles yields exactly 4 pulse cycles on each one-bit.
- R5: At the edge that first samples `wr_strobe` high, the block stores the whole 12-bit `wr_data` word. Bits 7:0 and bits 11:8 are held in separate banks, and a later read returns the full word.
- R6: A write strobe edge with no read strobe edge since the previous write stores `wr_data` at the current `addr`. In that case `proto_err` is high for exactly the one cycle after that edge. A write that follows a read leaves `proto_err` low.
- R7: Strobe edges seen while `sel` is low start no cycle. They give no sense pulses and change no stored word.
- R8: An all-zero word gives no pulse on any bit. An all-ones word gives a pulse on all 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Module select; strobe edges count only while high |
| addr | input | 12 | Word address, bused to every module |
| rd_strobe | input | 1 | Read-portion strobe |
| wr_strobe | input | 1 | Write-portion strobe |
| wr_data | input | 12 | Restore / write data, valid for the whole write strobe |
| sense_out | output | 12 | Registered sense pulses, one line per data bit |
| proto_err | output | 1 | One-cycle flag for a write with no preceding read |

## Verification
The hardest case to reach is a word that does not go back where the bus currently points. This happens when a cycle keeps its captured address while `addr` moves to another location between the read and write strobes. The bench swaps the address mid-cycle, then reads both locations to show that only the captured one changed. It also starts read strobes of full and shortened length and counts pulse cycles per bit. It fills and reads back every location, including all-zero and all-ones words, while a per-clock reference model of the window and storage is compared on every cycle.

// File: rtl/cmem_pkg.sv
package cmem_pkg;
  localparam int unsigned ADDR_W_DEF  = 12;
  localparam int unsigned DATA_W_DEF  = 12;
  localparam int unsigned LO_W_DEF    = 8;
  localparam int unsigned WIN_OPEN    = 15;
  localparam int unsigned WIN_CLOSE   = 25;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_ARMED = 2'd2
  } cyc_phase_t;
endpackage

// File: rtl/cmem_bank.sv
module cmem_bank #(
  parameter int unsigned AW = 12,
  parameter int unsigned W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/cmem_timer.sv
module cmem_timer
  import cmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned OPEN   = WIN_OPEN,
  parameter int unsigned CLOSE  = WIN_CLOSE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rd_strobe,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_en,
  output logic              window,
  output logic              orphan
);
  localparam int unsigned CNT_W = $clog2(CLOSE + 1);

  logic             rd_d, wr_d, rd_rise, wr_rise;
  logic [CNT_W-1:0] cnt;
  cyc_phase_t       phase;
  logic             active;

  assign rd_rise = sel & rd_strobe & ~rd_d;
  assign wr_rise = sel & wr_strobe & ~wr_d;
  assign active  = (phase == CYC_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d     <= 1'b0;
      wr_d     <= 1'b0;
      cnt      <= '0;
      phase    <= CYC_IDLE;
      lat_addr <= '0;
    end else begin
      rd_d <= rd_strobe;
      wr_d <= wr_strobe;
      if (rd_rise) begin
        lat_addr <= addr;
        cnt      <= '0;
        phase    <= CYC_READ;
      end else if (wr_rise) begin
        phase <= CYC_IDLE;
      end else if (active) begin
        if (!rd_strobe)                  phase <= CYC_ARMED;
        else if (cnt != CNT_W'(CLOSE))   cnt   <= cnt + 1'b1;
      end
    end
  end

  assign window  = active & rd_strobe & (cnt >= CNT_W'(OPEN)) & (cnt < CNT_W'(CLOSE));
  assign wr_en   = wr_rise;
  assign orphan  = wr_rise & (phase == CYC_IDLE);
  assign wr_addr = (phase == CYC_IDLE) ? addr : lat_addr;

  // R2: captured address only moves on a selected read strobe edge
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_rise |=> $stable(lat_addr));

  // R7: a cycle starts only while the module is selected
  assert_desel_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!sel && phase != CYC_READ) |=> phase != CYC_READ);
endmodule

// File: rtl/cmem_emu.sv
module cmem_emu
  import cmem_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned LO_W   = LO_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_strobe,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sense_out,
  output logic              proto_err
);
  localparam int unsigned HI_W = DATA_W - LO_W;

  logic [ADDR_W-1:0] lat_addr, wr_addr;
  logic              wr_en, window, orphan;
  logic [DATA_W-1:0] rdata;

  cmem_timer #(.ADDR_W(ADDR_W), .OPEN(WIN_OPEN), .CLOSE(WIN_CLOSE)) u_timer (
    .clk(clk), .rst(rst), .sel(sel), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .addr(addr), .lat_addr(lat_addr), .wr_addr(wr_addr), .wr_en(wr_en),
    .window(window), .orphan(orphan)
  );

  generate
    if (HI_W > 0) begin : g_split
      cmem_bank #(.AW(ADDR_W), .W(LO_W)) u_lo (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data[LO_W-1:0]),
        .raddr(lat_addr), .rdata(rdata[LO_W-1:0])
      );
      cmem_bank #(.AW(ADDR_W), .W(HI_W)) u_hi (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data[DATA_W-1:LO_W]),
        .raddr(lat_addr), .rdata(rdata[DATA_W-1:LO_W])
      );
    end else begin : g_single
      cmem_bank #(.AW(ADDR_W), .W(DATA_W)) u_all (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .raddr(lat_addr), .rdata(rdata)
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_out <= '0;
      proto_err <= 1'b0;
    end else begin
      sense_out <= window ? rdata : '0;
      proto_err <= orphan;
    end
  end

  // R1: outputs quiet coming out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (sense_out == '0 && !proto_err));

  // R4: no pulse unless the read strobe was high at the sampling edge
  assert_pulse_in_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (sense_out != '0) |-> $past(rd_strobe));

  // R6: the error flag is a single-cycle pulse
  assert_err_single_R6: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> !proto_err);

  // R6: the error flag follows a selected write strobe
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> ($past(wr_strobe) && $past(sel)));
endmodule

// File: tb/cmem_emu_test.sv
module cmem_emu_test;
  localparam int AW = 12;
  localparam int DW = 12;
  localparam int DEPTH = 1 << AW;
  localparam int LIMIT = 190000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_strobe = 1'b0;
  logic          wr_strobe = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] sense_out;
  logic          proto_err;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int pulse_cnt [DW];

  cmem_emu uut (
    .clk(clk), .rst(rst), .sel(sel), .addr(addr), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .sense_out(sense_out),
    .proto_err(proto_err)
  );

  always #5 clk = ~clk;

  // reference model
  int            m_mem [DEPTH];
  logic          m_rdd = 1'b0, m_wrd = 1'b0, m_live = 1'b0, m_seen = 1'b0;
  int            m_since = 0;
  int            m_lat = 0;
  logic [DW-1:0] exp_sense = '0;
  logic          exp_err = 1'b0;

  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;

  always @(posedge clk) begin
    logic rr, wr;
    cycles++;
    if (rst) begin
      m_rdd = 0; m_wrd = 0; m_live = 0; m_seen = 0; m_since = 0; m_lat = 0;
      exp_sense = '0; exp_err = 0;
    end else begin
      rr = sel && rd_strobe && !m_rdd;
      wr = sel && wr_strobe && !m_wrd;
      exp_sense = (m_live && rd_strobe && m_since >= 15 && m_since < 25)
                  ? DW'(m_mem[m_lat]) : '0;
      exp_err = wr && !m_seen && !m_live;
      if (wr) begin
        if (m_seen || m_live) m_mem[m_lat] = int'(wr_data);
        else                  m_mem[int'(addr)] = int'(wr_data);
      end
      if (rr) begin
        m_lat = int'(addr); m_since = 0; m_live = 1; m_seen = 1;
      end else if (wr) begin
        m_live = 0; m_seen = 0;
      end else if (m_live) begin
        if (!rd_strobe) m_live = 0;
        else m_since++;
      end
      m_rdd = rd_strobe;
      m_wrd = wr_strobe;
    end
  end

  always @(negedge clk) begin
    if (!rst && cycles > 1) begin
      tests++;
      if (sense_out !== exp_sense) begin
        fails++;
        $display("FAIL R3 sense_out=%h expected %h at cycle %0d", sense_out, exp_sense, cycles);
      end
      tests++;
      if (proto_err !== exp_err) begin
        fails++;
        $display("FAIL R6 proto_err=%b expected %b at cycle %0d", proto_err, exp_err, cycles);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles >= LIMIT) begin
      fails++;
      $display("FAIL watchdog expired actual %0d cycles expected below %0d", cycles, LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [DW-1:0] pat(int a);
    if (a == 0) return '0;
    if (a == 1) return '1;
    return DW'((a * 32'h9E3) ^ (a >> 3) ^ 32'h5A5);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    for (int b = 0; b < DW; b++) if (sense_out[b]) pulse_cnt[b]++;
  endtask

  // full cycle: read strobe rd_len clocks, gap, write strobe wr_len clocks, gap
  task automatic mem_cycle(logic [AW-1:0] a, logic [AW-1:0] a_late, logic [DW-1:0] d,
                           int rd_len, int wr_len);
    for (int b = 0; b < DW; b++) pulse_cnt[b] = 0;
    addr = a; rd_strobe = 1'b1;
    tick();
    addr = a_late;
    for (int i = 1; i < rd_len; i++) tick();
    rd_strobe = 1'b0;
    tick();
    tick();
    wr_data = d; wr_strobe = 1'b1;
    for (int i = 0; i < wr_len; i++) tick();
    wr_strobe = 1'b0;
    tick();
  endtask

  task automatic expect_pulses(string req, logic [DW-1:0] word, int n);
    for (int b = 0; b < DW; b++)
      check(req, 32'(pulse_cnt[b]), word[b] ? 32'(n) : 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sense", 32'(sense_out), 32'd0);
    check("R1 err", 32'(proto_err), 32'd0);
    rst = 1'b0;
    sel = 1'b1;
    @(negedge clk);
    check("R1 sense after release", 32'(sense_out), 32'd0);

    // fill every location with short cycles
    for (int a = 0; a < DEPTH; a++) mem_cycle(AW'(a), AW'(a), pat(a), 1, 1);

    // read back every location, restoring the same word
    for (int a = 0; a < DEPTH; a++) begin
      mem_cycle(AW'(a), AW'(a), pat(a), 28, 1);
      if (a < 2) expect_pulses("R8 corner word", pat(a), 10);
      else if (a % 97 == 0) expect_pulses("R3 pulse count", pat(a), 10);
    end

    // R5: word spanning both banks
    mem_cycle(12'h123, 12'h123, 12'hA5C, 1, 1);
    mem_cycle(12'h123, 12'h123, 12'hA5C, 28, 1);
    expect_pulses("R5 both banks", 12'hA5C, 10);

    // R2: address moves during the cycle; write must go to captured address
    mem_cycle(12'h200, 12'h300, 12'h3C3, 28, 1);
    expect_pulses("R2 old word", pat(12'h200), 10);
    mem_cycle(12'h200, 12'h200, 12'h3C3, 28, 1);
    expect_pulses("R2 captured addr written", 12'h3C3, 10);
    mem_cycle(12'h300, 12'h300, pat(12'h300), 28, 1);
    expect_pulses("R2 bus addr untouched", pat(12'h300), 10);

    // R4: shortened read strobe gives 4 pulse cycles
    mem_cycle(12'h001, 12'h001, 12'hFFF, 20, 1);
    expect_pulses("R4 short strobe", 12'hFFF, 4);

    // R6: orphan write
    addr = 12'h044; wr_data = 12'h6B1; wr_strobe = 1'b1;
    @(negedge clk);
    check("R6 err pulse", 32'(proto_err), 32'd1);
    wr_strobe = 1'b0;
    @(negedge clk);
    check("R6 err cleared", 32'(proto_err), 32'd0);
    mem_cycle(12'h044, 12'h044, 12'h6B1, 28, 1);
    expect_pulses("R6 orphan stored", 12'h6B1, 10);

    // R7: deselected strobes do nothing
    sel = 1'b0;
    mem_cycle(12'h055, 12'h055, 12'h000, 28, 1);
    expect_pulses("R7 no sense when deselected", 12'h000, 0);
    sel = 1'b1;
    mem_cycle(12'h055, 12'h055, pat(12'h055), 28, 1);
    expect_pulses("R7 word unchanged", pat(12'h055), 10);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule